// File: doc/BRIEF.md
# Nibble-Serial Bus Peripheral Target Engine

This block is the peripheral end of a four-wire multiplexed legacy I/O bus clocked by the bus clock. It watches an active-low frame strobe and four address/data lines. When the host opens a target cycle, the engine works out the space and the direction. It then collects the address one nibble per clock and checks that address against a programmable base and mask for each space. A cycle that matches is carried through the rest of its phases: bus turnaround, a sync handshake that can stretch the cycle, and a single data byte sent as two nibbles. The engine never drives the lines for a cycle that misses, and it never drives them for any cycle type it does not serve.

On the local side, a plain request/ready interface reaches the register bank behind the engine. It carries the decoded address, a space flag, the write byte and the read byte. The local side decides how long the bus cycle lasts by holding ready low. While ready is low the engine reports wait codes on the bus. These start as short waits and turn into long waits once a fixed number of short waits has been sent. The host can cut off any cycle by pulling the frame strobe low again.

Top module: `nbus_target`

## Requirements
- R1: While reset is asserted, and on the first clock after it, the drive enable is low and neither local request is asserted.
- R2: A cycle opens only on a clock where the frame strobe is low and the lines carry 4'h0. A low frame with any other nibble, or 4'h0 with the frame high, opens nothing and leaves the lines undriven.
- R3: The clock after the opening nibble carries the type: bits [3:2] = 2'b00 selects I/O and 2'b01 selects memory, and bit 1 gives the direction (0 read, 1 write). A type nibble with bit 3 set (for example 4'h8) is ignored, and the lines stay undriven.
- R4: The address arrives most significant nibble first: 4 nibbles (16 bits) for I/O and 8 nibbles (32 bits) for memory. It is presented on locAddr, with I/O addresses zero-extended, and locIsMem marks memory cycles.
- R5: A cycle matches when ((address ^ base) & mask) == 0, using the base and mask of its space. A cycle that does not match leaves the enable low and raises no local request.
- R6: On a matched read, the two clocks after the address are left undriven, then the sync code follows. The next two clocks carry the data byte, low nibble first, and then 4'hF is driven for one clock before the lines are released.
- R7: On a matched write, the host sends two data nibbles after the address, low nibble first. Two undriven turnaround clocks follow, then the sync code, then 4'hF for one clock, then release. The byte appears on locWdata.
- R8: Sync codes: 4'h0 means ready. While locReady is sampled low, 4'h5 (short wait) is sent for at most 7 clocks and 4'h6 (long wait) after that, with no limit. The ready code is sent on the clock after locReady is first sampled high.
- R9: locRead or locWrite, chosen by direction, is high from the second turnaround clock until the clock edge where locReady is sampled high. The transfer takes place at that edge, and the request is low on the next clock.
- R10: A low frame strobe during a cycle aborts it. The enable is low on the next clock, the requests drop, and a 4'h0 nibble on that clock opens a new cycle.
- R11: The enable stays low through the opening, type, address and host-data clocks and through both host-to-peripheral turnaround clocks. It rises only right after a clock on which a local request was asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | Active-low frame strobe from the host |
| busIn | input | 4 | Sampled address/data lines |
| busOut | output | 4 | Nibble to drive onto the lines |
| busOe | output | 1 | Drive enable for busOut; lines are high impedance when low |
| ioBase | input | IO_AW | I/O decode base |
| ioMask | input | IO_AW | I/O decode mask, 1 = bit compared |
| memBase | input | MEM_AW | Memory decode base |
| memMask | input | MEM_AW | Memory decode mask, 1 = bit compared |
| locAddr | output | MEM_AW | Decoded cycle address |
| locIsMem | output | 1 | High for a memory-space cycle |
| locRead | output | 1 | Local read request |
| locWrite | output | 1 | Local write request |
| locWdata | output | 8 | Byte received on a write |
| locRdata | input | 8 | Byte to return on a read, taken when locReady is high |
| locReady | input | 1 | Local ready; holds the cycle in wait while low |

## Verification
The assertions assume that the decode base and mask stay constant while a cycle is in flight. They also assume that locReady matters only while a request is up, and that the host holds the frame strobe high through the data and sync phases unless it means to abort. The stimulus keeps to these assumptions: the configuration is fixed for the whole run, the bench's local responder raises ready only after a chosen number of request clocks, and the frame strobe goes low mid-cycle only in the dedicated abort scenarios. Under those conditions the sweeps cover every I/O and memory offset in the decoded window, in both directions and with several wait lengths.

// File: rtl/nbus_target_pkg.sv
package nbus_target_pkg;

  localparam logic [3:0] NIB_START  = 4'h0;
  localparam logic [3:0] SYNC_READY = 4'h0;
  localparam logic [3:0] SYNC_SHORT = 4'h5;
  localparam logic [3:0] SYNC_LONG  = 4'h6;
  localparam logic [3:0] NIB_ONES   = 4'hF;

  typedef enum logic [1:0] {
    SEL_CODE,
    SEL_DLO,
    SEL_DHI
  } outSel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTYPE,
    ST_ADDR,
    ST_WDLO,
    ST_WDHI,
    ST_TARIN,
    ST_SYNC,
    ST_DRDY,
    ST_DRDLO,
    ST_DRDHI,
    ST_TAROUT
  } engState_e;

  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic       clrAddr;
    logic       shiftAddr;
    logic       loadSpace;
    logic       loadWlo;
    logic       loadWhi;
    logic       capRdata;
    logic       driveNext;
    outSel_e    outSel;
    logic [3:0] outCode;
  } dpStrobe_t;

endpackage

// File: rtl/nbus_target_dp.sv
module nbus_target_dp
  import nbus_target_pkg::*;
#(
  parameter int IO_AW  = 16,
  parameter int MEM_AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busIn,
  input  dpStrobe_t         str,
  input  logic [IO_AW-1:0]  ioBase,
  input  logic [IO_AW-1:0]  ioMask,
  input  logic [MEM_AW-1:0] memBase,
  input  logic [MEM_AW-1:0] memMask,
  input  logic [7:0]        locRdata,
  output logic              addrHit,
  output logic              spaceMem,
  output logic [MEM_AW-1:0] addrQ,
  output logic [7:0]        wdataQ,
  output logic [3:0]        busOut,
  output logic              busOe
);

  logic [MEM_AW-1:0] addrShift;
  logic [7:0]        rdataQ;
  logic              ioHit;
  logic              memHit;
  logic [3:0]        outNext;

  // Address as it will stand once the current nibble is shifted in
  assign addrShift = {addrQ[MEM_AW-5:0], busIn};
  assign ioHit     = ((addrShift[IO_AW-1:0] ^ ioBase) & ioMask) == '0;
  assign memHit    = ((addrShift ^ memBase) & memMask) == '0;
  assign addrHit   = spaceMem ? memHit : ioHit;

  always_comb begin
    unique case (str.outSel)
      SEL_DLO: outNext = rdataQ[3:0];
      SEL_DHI: outNext = rdataQ[7:4];
      default: outNext = str.outCode;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      spaceMem <= 1'b0;
      wdataQ   <= '0;
      rdataQ   <= '0;
      busOut   <= '0;
      busOe    <= 1'b0;
    end else begin
      if (str.clrAddr)        addrQ <= '0;
      else if (str.shiftAddr) addrQ <= addrShift;
      if (str.loadSpace) spaceMem    <= busIn[2];
      if (str.loadWlo)   wdataQ[3:0] <= busIn;
      if (str.loadWhi)   wdataQ[7:4] <= busIn;
      if (str.capRdata)  rdataQ      <= locRdata;
      busOe  <= str.driveNext;
      busOut <= str.driveNext ? outNext : 4'h0;
    end
  end

endmodule

// File: rtl/nbus_target_ctrl.sv
module nbus_target_ctrl
  import nbus_target_pkg::*;
#(
  parameter int IO_AW     = 16,
  parameter int MEM_AW    = 32,
  parameter int SHORT_MAX = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic [3:0] busIn,
  input  logic       addrHit,
  input  logic       spaceMem,
  input  logic       locReady,
  output dpStrobe_t  str,
  output logic       locRead,
  output logic       locWrite
);

  localparam int IO_NIBS  = IO_AW / 4;
  localparam int MEM_NIBS = MEM_AW / 4;
  localparam int CNT_W    = $clog2(MEM_NIBS);
  localparam int WAIT_W   = $clog2(SHORT_MAX + 1) + 1;
  localparam logic [CNT_W-1:0]  IO_LAST  = CNT_W'(IO_NIBS - 1);
  localparam logic [CNT_W-1:0]  MEM_LAST = CNT_W'(MEM_NIBS - 1);
  localparam logic [WAIT_W-1:0] WAIT_LIM = WAIT_W'(SHORT_MAX);

  engState_e         state, stateN;
  logic              isWrite, isWriteN;
  logic              tarSecond, tarSecondN;
  logic [CNT_W-1:0]  nibCnt, nibCntN;
  logic [WAIT_W-1:0] waitCnt, waitCntN;
  logic              reqPhase;

  assign reqPhase = ((state == ST_TARIN) && tarSecond) || (state == ST_SYNC);
  assign locRead  = reqPhase && !isWrite && frameN;
  assign locWrite = reqPhase && isWrite && frameN;

  always_comb begin
    str        = '0;
    str.outSel = SEL_CODE;
    stateN     = state;
    isWriteN   = isWrite;
    tarSecondN = tarSecond;
    nibCntN    = nibCnt;
    waitCntN   = waitCnt;
    if (!frameN) begin
      // Low frame: abort whatever runs, and test for a fresh opening nibble
      stateN = (busIn == NIB_START) ? ST_CTYPE : ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: stateN = ST_IDLE;
        ST_CTYPE: begin
          if (!busIn[3]) begin
            str.loadSpace = 1'b1;
            str.clrAddr   = 1'b1;
            isWriteN      = busIn[1];
            nibCntN       = '0;
            stateN        = ST_ADDR;
          end else begin
            stateN = ST_IDLE;
          end
        end
        ST_ADDR: begin
          str.shiftAddr = 1'b1;
          if (nibCnt == (spaceMem ? MEM_LAST : IO_LAST)) begin
            tarSecondN = 1'b0;
            if (!addrHit)     stateN = ST_IDLE;
            else if (isWrite) stateN = ST_WDLO;
            else              stateN = ST_TARIN;
          end else begin
            nibCntN = nibCnt + 1'b1;
          end
        end
        ST_WDLO: begin
          str.loadWlo = 1'b1;
          stateN      = ST_WDHI;
        end
        ST_WDHI: begin
          str.loadWhi = 1'b1;
          tarSecondN  = 1'b0;
          stateN      = ST_TARIN;
        end
        ST_TARIN: begin
          if (!tarSecond) begin
            tarSecondN = 1'b1;
          end else begin
            str.driveNext = 1'b1;
            if (locReady) begin
              str.outCode  = SYNC_READY;
              str.capRdata = !isWrite;
              stateN       = ST_DRDY;
            end else begin
              str.outCode = SYNC_SHORT;
              waitCntN    = WAIT_W'(1);
              stateN      = ST_SYNC;
            end
          end
        end
        ST_SYNC: begin
          str.driveNext = 1'b1;
          if (locReady) begin
            str.outCode  = SYNC_READY;
            str.capRdata = !isWrite;
            stateN       = ST_DRDY;
          end else if (waitCnt >= WAIT_LIM) begin
            str.outCode = SYNC_LONG;
          end else begin
            str.outCode = SYNC_SHORT;
            waitCntN    = waitCnt + 1'b1;
          end
        end
        ST_DRDY: begin
          str.driveNext = 1'b1;
          if (isWrite) begin
            str.outCode = NIB_ONES;
            stateN      = ST_TAROUT;
          end else begin
            str.outSel = SEL_DLO;
            stateN     = ST_DRDLO;
          end
        end
        ST_DRDLO: begin
          str.driveNext = 1'b1;
          str.outSel    = SEL_DHI;
          stateN        = ST_DRDHI;
        end
        ST_DRDHI: begin
          str.driveNext = 1'b1;
          str.outCode   = NIB_ONES;
          stateN        = ST_TAROUT;
        end
        ST_TAROUT: stateN = ST_IDLE;
        default:   stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      isWrite   <= 1'b0;
      tarSecond <= 1'b0;
      nibCnt    <= '0;
      waitCnt   <= '0;
    end else begin
      state     <= stateN;
      isWrite   <= isWriteN;
      tarSecond <= tarSecondN;
      nibCnt    <= nibCntN;
      waitCnt   <= waitCntN;
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((locRead || locWrite) && !locReady) |=> ((locRead || locWrite) || !frameN));

  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((locRead || locWrite) && locReady) |=> !(locRead || locWrite));

endmodule

// File: rtl/nbus_target.sv
module nbus_target
  import nbus_target_pkg::*;
#(
  parameter int IO_AW     = 16,
  parameter int MEM_AW    = 32,
  parameter int SHORT_MAX = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [3:0]        busIn,
  output logic [3:0]        busOut,
  output logic              busOe,
  input  logic [IO_AW-1:0]  ioBase,
  input  logic [IO_AW-1:0]  ioMask,
  input  logic [MEM_AW-1:0] memBase,
  input  logic [MEM_AW-1:0] memMask,
  output logic [MEM_AW-1:0] locAddr,
  output logic              locIsMem,
  output logic              locRead,
  output logic              locWrite,
  output logic [7:0]        locWdata,
  input  logic [7:0]        locRdata,
  input  logic              locReady
);

  dpStrobe_t str;
  logic      addrHit;
  logic      spaceMem;

  nbus_target_ctrl #(
    .IO_AW(IO_AW), .MEM_AW(MEM_AW), .SHORT_MAX(SHORT_MAX)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .frameN(frameN), .busIn(busIn),
    .addrHit(addrHit), .spaceMem(spaceMem), .locReady(locReady),
    .str(str), .locRead(locRead), .locWrite(locWrite)
  );

  nbus_target_dp #(
    .IO_AW(IO_AW), .MEM_AW(MEM_AW)
  ) i_dp (
    .clk(clk), .rstN(rstN), .busIn(busIn), .str(str),
    .ioBase(ioBase), .ioMask(ioMask), .memBase(memBase), .memMask(memMask),
    .locRdata(locRdata), .addrHit(addrHit), .spaceMem(spaceMem),
    .addrQ(locAddr), .wdataQ(locWdata), .busOut(busOut), .busOe(busOe)
  );

  assign locIsMem = spaceMem;

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameN |=> !busOe);

  // R11
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busOe) |-> $past(locRead || locWrite));

  // R8
  long_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && (busOut == SYNC_LONG) && (locRead || locWrite))
      |=> (!busOe || busOut == SYNC_LONG || busOut == SYNC_READY));

endmodule

// File: tb/test_nbus_target.sv
module test_nbus_target;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IO_BASE  = 16'h0060;
  localparam logic [15:0] IO_MASK  = 16'hFFF0;
  localparam logic [31:0] MEM_BASE = 32'hFEDC_0000;
  localparam logic [31:0] MEM_MASK = 32'hFFFF_FFF0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic [3:0]  busIn = 4'hF;
  logic [3:0]  busOut;
  logic        busOe;
  logic [31:0] locAddr;
  logic        locIsMem, locRead, locWrite, locReady;
  logic [7:0]  locWdata, locRdata;

  int checks = 0;
  int failures = 0;
  int readyDelay = 0;
  int reqCnt = 0;
  bit done = 1'b0;
  logic [7:0] store [32];
  logic [7:0] expStore [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  nbus_target i_nbus_target (
    .clk(clk), .rstN(rstN), .frameN(frameN), .busIn(busIn),
    .busOut(busOut), .busOe(busOe),
    .ioBase(IO_BASE), .ioMask(IO_MASK), .memBase(MEM_BASE), .memMask(MEM_MASK),
    .locAddr(locAddr), .locIsMem(locIsMem), .locRead(locRead), .locWrite(locWrite),
    .locWdata(locWdata), .locRdata(locRdata), .locReady(locReady)
  );

  // Local responder: ready after readyDelay request clocks
  assign locReady = (locRead || locWrite) && (reqCnt >= readyDelay);
  assign locRdata = store[{locIsMem, locAddr[3:0]}];

  always @(posedge clk) begin
    if ((locRead || locWrite) && !locReady) reqCnt <= reqCnt + 1;
    else                                     reqCnt <= 0;
  end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) store[i] <= 8'(i * 29 + 11);
    end else if (locWrite && locReady) begin
      store[{locIsMem, locAddr[3:0]}] <= locWdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Host drives one clock of the bus; the lines must be undriven then
  task automatic hostDrive(input logic fr, input logic [3:0] nib);
    @(negedge clk);
    chk(busOe == 1'b0, "R11", "enable during host clock", 32'(busOe), 32'h0);
    frameN = fr;
    busIn  = nib;
  endtask

  task automatic idleClocks(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      frameN = 1'b1;
      busIn  = 4'hF;
      chk(busOe == 1'b0 && !locRead && !locWrite, req, "no drive or request",
          {29'h0, busOe, locRead, locWrite}, 32'h0);
    end
  endtask

  task automatic runCycle(input bit isMem, input bit isWr, input logic [31:0] addr,
                          input logic [7:0] wd, input int delay, input bit hit);
    int nibs;
    int waits;
    logic [3:0] code;
    logic [31:0] expAddr;
    logic [4:0] idx;
    nibs = isMem ? 8 : 4;
    expAddr = isMem ? addr : {16'h0, addr[15:0]};
    idx = {isMem, addr[3:0]};
    readyDelay = delay;
    hostDrive(1'b0, 4'h0);
    hostDrive(1'b1, {1'b0, isMem, isWr, 1'b0});
    for (int k = nibs - 1; k >= 0; k--) hostDrive(1'b1, addr[k*4 +: 4]);
    if (!hit) begin
      idleClocks(8, "R5");
      return;
    end
    if (isWr) begin
      hostDrive(1'b1, wd[3:0]);
      hostDrive(1'b1, wd[7:4]);
    end
    hostDrive(1'b1, 4'hF);
    hostDrive(1'b1, 4'hF);
    chk(locAddr == expAddr, "R4", "local address", locAddr, expAddr);
    chk(locIsMem == isMem, "R4", "space flag", 32'(locIsMem), 32'(isMem));
    chk(locRead == !isWr && locWrite == isWr, "R9", "request raised",
        {30'h0, locRead, locWrite}, {30'h0, !isWr, isWr});
    if (isWr) chk(locWdata == wd, "R7", "write byte", 32'(locWdata), 32'(wd));
    waits = 0;
    forever begin
      @(negedge clk);
      code = (waits >= delay) ? 4'h0 : ((waits < 7) ? 4'h5 : 4'h6);
      chk(busOe && busOut == code, "R8", "sync code", {27'h0, busOe, busOut}, {28'h1, code});
      if (code == 4'h0 || waits > 60) break;
      waits++;
    end
    if (isWr) begin
      @(negedge clk);
      chk(!locWrite, "R9", "request dropped", 32'(locWrite), 32'h0);
      chk(busOe && busOut == 4'hF, "R7", "final ones", {27'h0, busOe, busOut}, 32'h1F);
      @(negedge clk);
      chk(!busOe, "R7", "release", 32'(busOe), 32'h0);
      expStore[idx] = wd;
    end else begin
      @(negedge clk);
      chk(!locRead, "R9", "request dropped", 32'(locRead), 32'h0);
      chk(busOe && busOut == expStore[idx][3:0], "R6", "data low nibble",
          {27'h0, busOe, busOut}, {27'h0, 1'b1, expStore[idx][3:0]});
      @(negedge clk);
      chk(busOe && busOut == expStore[idx][7:4], "R6", "data high nibble",
          {27'h0, busOe, busOut}, {27'h0, 1'b1, expStore[idx][7:4]});
      @(negedge clk);
      chk(busOe && busOut == 4'hF, "R6", "final ones", {27'h0, busOe, busOut}, 32'h1F);
      @(negedge clk);
      chk(!busOe, "R6", "release", 32'(busOe), 32'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) expStore[i] = 8'(i * 29 + 11);
    repeat (3) @(negedge clk);
    chk(!busOe && !locRead && !locWrite, "R1", "in reset",
        {29'h0, busOe, locRead, locWrite}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busOe && !locRead && !locWrite, "R1", "after reset",
        {29'h0, busOe, locRead, locWrite}, 32'h0);

    // R7 / R6 sweeps over every offset of both windows
    for (int i = 0; i < 16; i++)
      runCycle(1'b0, 1'b1, 32'h0060 + 32'(i), 8'(i * 37 + 5), i % 3, 1'b1);
    for (int i = 0; i < 16; i++)
      runCycle(1'b1, 1'b1, MEM_BASE + 32'(i), 8'(~(i * 13)), (i % 2) * 2, 1'b1);
    for (int i = 0; i < 16; i++)
      runCycle(1'b0, 1'b0, 32'h0060 + 32'(i), 8'h00, i % 5, 1'b1);
    for (int i = 0; i < 16; i++)
      runCycle(1'b1, 1'b0, MEM_BASE + 32'(i), 8'h00, 0, 1'b1);

    // R8 long waits
    runCycle(1'b0, 1'b0, 32'h0063, 8'h00, 9, 1'b1);
    runCycle(1'b1, 1'b1, MEM_BASE + 32'h5, 8'hC3, 12, 1'b1);
    runCycle(1'b1, 1'b0, MEM_BASE + 32'h5, 8'h00, 7, 1'b1);

    // R5 misses
    runCycle(1'b0, 1'b0, 32'h0070, 8'h00, 0, 1'b0);
    runCycle(1'b0, 1'b1, 32'h0160, 8'h11, 0, 1'b0);
    runCycle(1'b0, 1'b0, 32'h005F, 8'h00, 0, 1'b0);
    runCycle(1'b1, 1'b0, 32'hFEDD_0003, 8'h00, 0, 1'b0);
    runCycle(1'b1, 1'b1, 32'h7EDC_0001, 8'h22, 0, 1'b0);
    runCycle(1'b0, 1'b0, 32'h0064, 8'h00, 0, 1'b1);

    // R2 other opening nibbles, and 4'h0 with frame high
    hostDrive(1'b0, 4'hD);
    hostDrive(1'b1, 4'h0);
    for (int k = 0; k < 4; k++) hostDrive(1'b1, 4'h0);
    hostDrive(1'b1, 4'h6);
    idleClocks(6, "R2");

    // R3 unsupported type nibble
    hostDrive(1'b0, 4'h0);
    hostDrive(1'b1, 4'h8);
    for (int k = 0; k < 8; k++) hostDrive(1'b1, 4'h0);
    idleClocks(6, "R3");

    // R10 restart in mid-address, then the new cycle completes
    hostDrive(1'b0, 4'h0);
    hostDrive(1'b1, 4'h0);
    hostDrive(1'b1, 4'h0);
    hostDrive(1'b1, 4'h0);
    runCycle(1'b0, 1'b0, 32'h006A, 8'h00, 1, 1'b1);

    // R10 abort during long sync wait
    readyDelay = 40;
    hostDrive(1'b0, 4'h0);
    hostDrive(1'b1, 4'h0);
    hostDrive(1'b1, 4'h0);
    hostDrive(1'b1, 4'h0);
    hostDrive(1'b1, 4'h6);
    hostDrive(1'b1, 4'h1);
    hostDrive(1'b1, 4'hF);
    hostDrive(1'b1, 4'hF);
    for (int k = 0; k < 9; k++) @(negedge clk);
    chk(busOe && busOut == 4'h6, "R8", "long wait before abort", {27'h0, busOe, busOut}, 32'h16);
    frameN = 1'b0;
    busIn  = 4'hF;
    #1;
    chk(!locRead, "R10", "request gated by frame", 32'(locRead), 32'h0);
    @(negedge clk);
    chk(!busOe && !locRead, "R10", "release after abort", {30'h0, busOe, locRead}, 32'h0);
    frameN = 1'b1;
    idleClocks(3, "R10");
    runCycle(1'b0, 1'b0, 32'h0061, 8'h00, 0, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule